// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a small table of perceptrons and selects one by the low bits of the branch address. Each perceptron has one signed weight for every bit of a global outcome history, plus a bias weight that does not depend on history. To predict, the block treats each history bit as +1 for taken or -1 for not-taken. It adds the bias to the signed sum of the weights multiplied by those values. A strictly positive sum means taken.

The front end issues a request with the branch address. A fixed two cycles later the block returns the direction, the signed sum, its magnitude, and the history that was used. The caller keeps the sum and the history next to the in-flight branch. When the branch resolves, the caller hands them back on the update port with the real outcome. The block then decides whether to train the selected perceptron and shifts the outcome into its global history.

Top module: `perceptron_predictor`

## Requirements
- R1: After reset every weight is zero and the global history is all zeros, so the first prediction has sum 0, is not-taken, and reports history 0.
- R2: A request taken in at a clock edge produces `out_valid` high for exactly one cycle, after the second following edge. `out_hist` is the global history as it stood when the request was taken in.
- R3: The sum equals the bias weight plus, for each history bit i, weight i when bit i is 1 (taken) and minus weight i when bit i is 0. Bit 0 is the newest outcome.
- R4: `out_taken` is 1 only when the sum is greater than zero, so a sum of exactly zero predicts not-taken. `out_mag` is the absolute value of the sum.
- R5: The perceptron is chosen by the branch address modulo ENTRIES, which is the low log2(ENTRIES) address bits. Two addresses that differ only above those bits share one perceptron.
- R6: An update trains the selected perceptron only in two cases. The first is when the stored sum's direction (taken when greater than zero) differs from the outcome. The second is when the stored sum's magnitude is at most THETA = floor(1.93*HIST_LEN + 14), which is 29 for the default length of 8. Otherwise the weights are unchanged.
- R7: When training, weight i rises by 1 if stored history bit i equals the outcome and falls by 1 otherwise. The bias rises by 1 on taken and falls by 1 on not-taken.
- R8: Weights saturate at +127 and -128 (WEIGHT_W = 8). A sum built from -128 weights negated by not-taken history bits is exact, without wraparound.
- R9: Every update shifts its outcome into bit 0 of the global history, whether or not training occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_req | input | 1 | Prediction request |
| pred_pc | input | PC_W | Branch address for the request |
| out_valid | output | 1 | Prediction result valid |
| out_taken | output | 1 | Predicted direction |
| out_y | output | SUM_W | Signed perceptron sum |
| out_mag | output | SUM_W | Magnitude of the sum |
| out_hist | output | HIST_LEN | History used for this prediction |
| upd_valid | input | 1 | Resolved-branch update |
| upd_pc | input | PC_W | Branch address of the resolved branch |
| upd_taken | input | 1 | Real outcome |
| upd_y | input | SUM_W | Sum stored at prediction time |
| upd_hist | input | HIST_LEN | History stored at prediction time |

## Verification
The bench targets the training threshold at exactly THETA and THETA+1. A design with an off-by-one compare would either keep training a confident branch or stop one step early, and its later sums would differ from the model. It drives every weight of one entry to +127 and then to -128. A design without saturation would wrap to the opposite sign, and a design that negates -128 within eight bits would return a wrong, negative sum instead of 896. It also checks that a zero sum predicts not-taken, that aliased addresses share state, and that history is captured at request time. Getting any of these wrong shows up as a mismatched sum, direction or history word.

// File: rtl/perceptron_predictor.sv
module perceptron_predictor #(
  parameter int HIST_LEN = 8,
  parameter int ENTRIES  = 16,
  parameter int WEIGHT_W = 8,
  parameter int PC_W     = 16
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         pred_req,
  input  logic [PC_W-1:0]                              pred_pc,
  output logic                                         out_valid,
  output logic                                         out_taken,
  output logic signed [WEIGHT_W+$clog2(HIST_LEN+1):0]  out_y,
  output logic [WEIGHT_W+$clog2(HIST_LEN+1):0]         out_mag,
  output logic [HIST_LEN-1:0]                          out_hist,
  input  logic                                         upd_valid,
  input  logic [PC_W-1:0]                              upd_pc,
  input  logic                                         upd_taken,
  input  logic signed [WEIGHT_W+$clog2(HIST_LEN+1):0]  upd_y,
  input  logic [HIST_LEN-1:0]                          upd_hist
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NW    = HIST_LEN + 1;
  localparam int SUM_W = WEIGHT_W + $clog2(HIST_LEN + 1) + 1;
  localparam int THETA = (193 * HIST_LEN + 1400) / 100;
  localparam logic signed [WEIGHT_W-1:0] W_MAX = {1'b0, {(WEIGHT_W-1){1'b1}}};
  localparam logic signed [WEIGHT_W-1:0] W_MIN = {1'b1, {(WEIGHT_W-1){1'b0}}};

  function automatic logic signed [SUM_W-1:0] signed_term(
    input logic signed [WEIGHT_W-1:0] w, input logic pos);
    logic signed [SUM_W-1:0] e;
    e = {{(SUM_W-WEIGHT_W){w[WEIGHT_W-1]}}, w};
    return pos ? e : -e;
  endfunction

  function automatic logic signed [WEIGHT_W-1:0] step_w(
    input logic signed [WEIGHT_W-1:0] w, input logic up);
    if (up) return (w == W_MAX) ? w : w + WEIGHT_W'(1);
    else    return (w == W_MIN) ? w : w - WEIGHT_W'(1);
  endfunction

  logic signed [WEIGHT_W-1:0] wt [ENTRIES][NW];
  logic [HIST_LEN-1:0]        ghr;
  logic [IDX_W-1:0]           p_idx, u_idx;
  logic                       unused_pc_hi;

  assign p_idx        = pred_pc[IDX_W-1:0];
  assign u_idx        = upd_pc[IDX_W-1:0];
  assign unused_pc_hi = ^{pred_pc[PC_W-1:IDX_W], upd_pc[PC_W-1:IDX_W]};

  // stage 1: signed terms of the selected perceptron
  logic                    s1_valid;
  logic signed [SUM_W-1:0] s1_term [NW];
  logic [HIST_LEN-1:0]     s1_hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hist  <= '0;
      for (int i = 0; i < NW; i++) s1_term[i] <= '0;
    end else begin
      s1_valid <= pred_req;
      if (pred_req) begin
        s1_hist <= ghr;
        for (int i = 0; i < HIST_LEN; i++)
          s1_term[i] <= signed_term(wt[p_idx][i], ghr[i]);
        s1_term[HIST_LEN] <= signed_term(wt[p_idx][HIST_LEN], 1'b1);
      end
    end
  end

  // stage 2: reduce and register the result
  logic signed [SUM_W-1:0] sum_c;
  always_comb begin
    sum_c = '0;
    for (int i = 0; i < NW; i++) sum_c = sum_c + s1_term[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
      out_y     <= '0;
      out_hist  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_taken <= sum_c > 0;
        out_y     <= sum_c;
        out_hist  <= s1_hist;
      end
    end
  end

  assign out_mag = out_y[SUM_W-1] ? SUM_W'(-out_y) : SUM_W'(out_y);

  // training
  logic             u_pred, do_train;
  logic [SUM_W-1:0] u_mag;

  assign u_pred   = upd_y > 0;
  assign u_mag    = upd_y[SUM_W-1] ? SUM_W'(-upd_y) : SUM_W'(upd_y);
  assign do_train = upd_valid && ((u_pred != upd_taken) || (u_mag <= SUM_W'(THETA)));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++)
        for (int i = 0; i < NW; i++) wt[e][i] <= '0;
    end else if (do_train) begin
      for (int i = 0; i < HIST_LEN; i++)
        wt[u_idx][i] <= step_w(wt[u_idx][i], upd_hist[i] == upd_taken);
      wt[u_idx][HIST_LEN] <= step_w(wt[u_idx][HIST_LEN], upd_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ghr <= '0;
    else if (upd_valid) ghr <= {ghr[HIST_LEN-2:0], upd_taken};
  end

  // checks on the bias weight of the trained entry
  logic                       chk_up_q, chk_hold_q;
  logic [IDX_W-1:0]           chk_idx_q;
  logic signed [WEIGHT_W-1:0] chk_bias_q, chk_bias_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_up_q   <= 1'b0;
      chk_hold_q <= 1'b0;
      chk_idx_q  <= '0;
      chk_bias_q <= '0;
    end else begin
      chk_up_q   <= do_train && upd_taken;
      chk_hold_q <= upd_valid && !do_train;
      chk_idx_q  <= u_idx;
      chk_bias_q <= wt[u_idx][HIST_LEN];
    end
  end
  assign chk_bias_now = wt[chk_idx_q][HIST_LEN];

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(pred_req, 2));
  p_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_taken) |-> (out_mag != '0 && !out_y[SUM_W-1]));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    chk_hold_q |-> chk_bias_now == chk_bias_q);
  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    (chk_up_q && chk_bias_q != W_MAX) |-> chk_bias_now == chk_bias_q + WEIGHT_W'(1));
  p_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (chk_up_q && chk_bias_q == W_MAX) |-> chk_bias_now == W_MAX);
  p_hist_r9: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ghr[0] == $past(upd_taken));

endmodule

// File: tb/test_perceptron_predictor.sv
module test_perceptron_predictor;
  localparam int H  = 8;
  localparam int E  = 16;
  localparam int SW = 13;
  localparam int THETA = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pred_req = 1'b0;
  logic [15:0] pred_pc = '0;
  logic out_valid, out_taken;
  logic signed [SW-1:0] out_y;
  logic [SW-1:0] out_mag;
  logic [H-1:0] out_hist;
  logic upd_valid = 1'b0;
  logic [15:0] upd_pc = '0;
  logic upd_taken = 1'b0;
  logic signed [SW-1:0] upd_y = '0;
  logic [H-1:0] upd_hist = '0;

  always #4 clk = ~clk;

  perceptron_predictor i_perceptron_predictor (
    .clk(clk), .rst(rst), .pred_req(pred_req), .pred_pc(pred_pc),
    .out_valid(out_valid), .out_taken(out_taken), .out_y(out_y),
    .out_mag(out_mag), .out_hist(out_hist), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_y(upd_y), .upd_hist(upd_hist));

  int n_tests = 0;
  int n_fail  = 0;
  int mw [E][H+1];
  logic [H-1:0] mghr = '0;

  localparam logic [16:0] VEC [24] = '{
    {16'd3,1'b1}, {16'd7,1'b0}, {16'd3,1'b1}, {16'd21,1'b1}, {16'd7,1'b0}, {16'd3,1'b0},
    {16'd21,1'b1}, {16'd7,1'b1}, {16'd3,1'b1}, {16'd7,1'b0}, {16'd21,1'b0}, {16'd3,1'b1},
    {16'd7,1'b0}, {16'd3,1'b1}, {16'd21,1'b1}, {16'd7,1'b0}, {16'd3,1'b1}, {16'd7,1'b1},
    {16'd21,1'b1}, {16'd3,1'b0}, {16'd7,1'b0}, {16'd3,1'b1}, {16'd21,1'b1}, {16'd7,1'b0}};

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_y(input int idx);
    int s = mw[idx][H];
    for (int i = 0; i < H; i++) s += mghr[i] ? mw[idx][i] : -mw[idx][i];
    return s;
  endfunction

  function automatic int clampw(input int v);
    return v > 127 ? 127 : (v < -128 ? -128 : v);
  endfunction

  task automatic model_upd(input int idx, input logic t, input int y, input logic [H-1:0] h);
    int mag = y < 0 ? -y : y;
    if (((y > 0) != t) || mag <= THETA) begin
      for (int i = 0; i < H; i++) mw[idx][i] = clampw(mw[idx][i] + ((h[i] == t) ? 1 : -1));
      mw[idx][H] = clampw(mw[idx][H] + (t ? 1 : -1));
    end
    mghr = {mghr[H-2:0], t};
  endtask

  task automatic predict(input logic [15:0] pc, input string req, output int y, output logic [H-1:0] hist);
    int ey = model_y(pc % E);
    logic [H-1:0] eh = mghr;
    @(negedge clk); pred_req = 1'b1; pred_pc = pc;
    @(negedge clk); pred_req = 1'b0;
    chk("R2 early valid", int'(out_valid), 0);
    @(negedge clk);
    chk("R2 valid", int'(out_valid), 1);
    chk({req, " sum"}, int'(out_y), ey);
    chk("R4 taken", int'(out_taken), int'(ey > 0));
    chk("R4 mag", int'(out_mag), ey < 0 ? -ey : ey);
    chk("R2 hist", int'(out_hist), int'(eh));
    y = int'(out_y); hist = out_hist;
  endtask

  task automatic update(input logic [15:0] pc, input logic t, input int y, input logic [H-1:0] h);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_y = SW'(y); upd_hist = h;
    @(negedge clk); upd_valid = 1'b0;
    model_upd(pc % E, t, y, h);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int y, y2;
    logic [H-1:0] hh;
    for (int e = 0; e < E; e++) for (int i = 0; i <= H; i++) mw[e][i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state and zero sum -> not taken (R4)
    predict(16'd0, "R1", y, hh);
    chk("R1 zero sum", y, 0);
    chk("R1 hist", int'(hh), 0);

    // R3 table walk with training R6 R7 R9
    for (int k = 0; k < 24; k++) begin
      predict(VEC[k][16:1], "R3", y, hh);
      update(VEC[k][16:1], VEC[k][0], y, hh);
    end

    // R5 aliasing
    predict(16'd3, "R5", y, hh);
    predict(16'd19, "R5", y2, hh);
    chk("R5 alias", y2, y);

    // R6 threshold boundary and mispredict with large magnitude
    update(16'd10, 1'b1, THETA, 8'h00);
    update(16'd10, 1'b1, THETA + 1, 8'h00);
    predict(16'd10, "R6 threshold", y, hh);
    update(16'd10, 1'b0, 100, 8'hAA);
    predict(16'd10, "R6 mispredict", y, hh);

    // R8 saturation high then low
    for (int k = 0; k < 140; k++) update(16'd12, 1'b1, 0, 8'hFF);
    predict(16'd12, "R8 high", y, hh);
    chk("R8 max sum", y, 9 * 127);
    for (int k = 0; k < 300; k++) update(16'd12, 1'b0, 0, 8'hFF);
    predict(16'd12, "R8 low", y, hh);
    chk("R8 min weights", y, 896);

    // R9 history order
    update(16'd0, 1'b1, 0, 8'h00);
    update(16'd0, 1'b0, 0, 8'h00);
    update(16'd0, 1'b1, 0, 8'h00);
    predict(16'd0, "R9", y, hh);
    chk("R9 order", int'(hh[2:0]), 5);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule